// File: doc/BRIEF.md
# Receive Buffer Watermark Flow-Control Requester

This block watches how full one port's receive buffer is and asks the transmit side of the MAC to send IEEE 802.3x flow-control frames. A byte counter rises by the number of bytes the receive path writes each cycle and falls by the number the system side reads. It is compared with two programmable thresholds. Reaching the upper one asks for a halt frame. Dropping below the lower one, after a halt, asks for a resume frame. Each request is presented on a valid/acknowledge handshake to the frame builder, which owns building and sending the frame.

A paused flag supplies the hysteresis, so the link partner sees one halt and one resume per congestion episode. A flow-control enable bit is set after reset, so the block acts without any setup. Software may rewrite both thresholds and the enable through a single write strobe.

Top module: `rx_wm_pause_gen`

## Requirements
- R1: After reset the occupancy is 0, the paused flag is 0, no request is pending, flow control is enabled, and the thresholds hold their parameter defaults (high 15360, low 8192).
- R2: At each clock the occupancy becomes occupancy + wr_bytes − rd_bytes, clamped to 0 below and to 2^CNT_W − 1 above. The default CNT_W of 15 covers 17408 bytes.
- R3: When flow control is enabled, the port is not paused, no request is pending and the registered occupancy is at or above the high threshold, the next clock raises req_valid with req_time 16'hFFFF and sets paused.
- R4: When the port is paused, no request is pending and the registered occupancy is below the effective low threshold, the next clock raises req_valid with req_time 16'h0000 and clears paused.
- R5: Only an entry to paused or an exit from it issues a request. Occupancy staying above the high threshold, or staying between the thresholds, issues nothing further.
- R6: A pending request keeps req_valid and req_time unchanged until req_ack is high at a clock. That clock clears req_valid, and no new request is issued on it. req_ack with no request pending has no effect.
- R7: With flow control disabled no halt is requested. If the port is paused when flow control is disabled, exactly one resume request is issued as soon as no request is pending.
- R8: If the programmed low threshold is greater than or equal to the high threshold, the effective low threshold is high − 1 (0 when high is 0).
- R9: A clock with cfg_we high loads cfg_hi, cfg_lo and cfg_en into the threshold and enable registers. The decisions from the next clock onward use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_bytes | input | INC_W | Bytes written into the receive buffer this cycle |
| rd_bytes | input | INC_W | Bytes read out of the receive buffer this cycle |
| cfg_we | input | 1 | Write strobe for the threshold and enable registers |
| cfg_hi | input | CNT_W | New high threshold |
| cfg_lo | input | CNT_W | New low threshold |
| cfg_en | input | 1 | New flow-control enable |
| req_ack | input | 1 | Frame builder accepts the pending request |
| occupancy | output | CNT_W | Current buffered byte count |
| paused | output | 1 | Link partner has been asked to halt |
| req_valid | output | 1 | Flow-control frame request pending |
| req_time | output | 16 | Pause quanta for the request: FFFF halt, 0000 resume |

## Verification
The hardest case to reach from the ports is a threshold crossing that happens while an earlier request is still waiting for its acknowledge. The decision must then be deferred, and it must be taken afresh from the occupancy at the moment the handshake completes. The bench reaches it by holding req_ack low for many cycles while it drives the occupancy through both thresholds. It also disables flow control during such a wait and programs a low threshold above the high one. A behavioural model checks occupancy, paused, req_valid and req_time on every clock.

// File: rtl/rx_wm_pause_gen.sv
module rx_wm_pause_gen #(
  parameter int CNT_W  = 15,
  parameter int INC_W  = 11,
  parameter int HI_RST = 15360,
  parameter int LO_RST = 8192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] wr_bytes,
  input  logic [INC_W-1:0] rd_bytes,
  input  logic             cfg_we,
  input  logic [CNT_W-1:0] cfg_hi,
  input  logic [CNT_W-1:0] cfg_lo,
  input  logic             cfg_en,
  input  logic             req_ack,
  output logic [CNT_W-1:0] occupancy,
  output logic             paused,
  output logic             req_valid,
  output logic [15:0]      req_time
);
  localparam logic [CNT_W:0]   OCC_MAX = {1'b0, {CNT_W{1'b1}}};
  localparam logic [15:0]      T_HALT  = 16'hFFFF;
  localparam logic [15:0]      T_GO    = 16'h0000;

  logic [CNT_W-1:0] hi_q, lo_q, lo_eff;
  logic             en_q;
  logic [CNT_W:0]   sum, diff;
  logic [CNT_W-1:0] occ_nxt;
  logic             go_halt, go_resume;

  assign sum  = {1'b0, occupancy} + (CNT_W+1)'(wr_bytes);
  assign diff = sum - (CNT_W+1)'(rd_bytes);

  always_comb begin
    if ((CNT_W+1)'(rd_bytes) > sum) occ_nxt = '0;
    else if (diff > OCC_MAX)        occ_nxt = OCC_MAX[CNT_W-1:0];
    else                            occ_nxt = diff[CNT_W-1:0];
  end

  assign lo_eff    = (lo_q < hi_q) ? lo_q : ((hi_q == '0) ? '0 : hi_q - 1'b1);
  assign go_halt   = !req_valid && en_q && !paused && (occupancy >= hi_q);
  assign go_resume = !req_valid && paused && (!en_q || (occupancy < lo_eff));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occupancy <= '0;
      hi_q      <= CNT_W'(HI_RST);
      lo_q      <= CNT_W'(LO_RST);
      en_q      <= 1'b1;
      paused    <= 1'b0;
      req_valid <= 1'b0;
      req_time  <= T_GO;
    end else begin
      occupancy <= occ_nxt;
      if (cfg_we) begin
        hi_q <= cfg_hi;
        lo_q <= cfg_lo;
        en_q <= cfg_en;
      end
      if (req_valid && req_ack) begin
        req_valid <= 1'b0;
      end else if (go_halt) begin
        paused    <= 1'b1;
        req_valid <= 1'b1;
        req_time  <= T_HALT;
      end else if (go_resume) begin
        paused    <= 1'b0;
        req_valid <= 1'b1;
        req_time  <= T_GO;
      end
    end
  end
endmodule

module rx_wm_pause_gen_chk #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ack,
  input logic             req_valid,
  input logic [15:0]      req_time,
  input logic             paused,
  input logic             en_q,
  input logic [CNT_W-1:0] occupancy,
  input logic [CNT_W-1:0] hi_q
);
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_time)); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ack |=> !req_valid); // R6
  AST_TIME_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_time == 16'hFFFF || req_time == 16'h0000)); // R3
  AST_HALT_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> req_valid && req_time == 16'hFFFF); // R5
  AST_RESUME_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) |-> req_valid && req_time == 16'h0000); // R4
  AST_NO_HALT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> $past(en_q) && $past(occupancy) >= $past(hi_q)); // R7
  AST_NO_SPONTANEOUS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> paused != $past(paused)); // R5
endmodule

bind rx_wm_pause_gen rx_wm_pause_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .req_valid(req_valid),
  .req_time(req_time), .paused(paused), .en_q(en_q),
  .occupancy(occupancy), .hi_q(hi_q)
);

// File: tb/tb_rx_wm_pause_gen.sv
module tb_rx_wm_pause_gen;
  localparam int CNT_W = 15;
  localparam int INC_W = 11;
  localparam int OMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [INC_W-1:0] wr_bytes = '0, rd_bytes = '0;
  logic cfg_we = 1'b0, cfg_en = 1'b1, req_ack = 1'b0;
  logic [CNT_W-1:0] cfg_hi = '0, cfg_lo = '0;
  logic [CNT_W-1:0] occupancy;
  logic paused, req_valid;
  logic [15:0] req_time;

  rx_wm_pause_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_bytes(wr_bytes), .rd_bytes(rd_bytes),
    .cfg_we(cfg_we), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .cfg_en(cfg_en),
    .req_ack(req_ack), .occupancy(occupancy), .paused(paused),
    .req_valid(req_valid), .req_time(req_time)
  );

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string tag = "R1";
  int m_occ, m_hi, m_lo, m_time;
  bit m_en, m_paused, m_valid;
  int halts = 0, resumes = 0;

  function automatic int lo_eff(int hi, int lo);
    if (lo < hi) return lo;
    return (hi == 0) ? 0 : hi - 1;
  endfunction

  task automatic chk(string r, int act, int exp, string what);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", r, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_occ = 0; m_hi = 15360; m_lo = 8192; m_en = 1; m_paused = 0; m_valid = 0; m_time = 0;
    end else begin
      int s, no, nh, nl; bit ne;
      s = m_occ + int'(wr_bytes);
      if (int'(rd_bytes) > s) no = 0;
      else if (s - int'(rd_bytes) > OMAX) no = OMAX;
      else no = s - int'(rd_bytes);
      nh = m_hi; nl = m_lo; ne = m_en;
      if (cfg_we) begin nh = int'(cfg_hi); nl = int'(cfg_lo); ne = cfg_en; end
      if (m_valid && req_ack) m_valid = 0;
      else if (!m_valid && m_en && !m_paused && m_occ >= m_hi) begin
        m_paused = 1; m_valid = 1; m_time = 16'hFFFF; halts++;
      end else if (!m_valid && m_paused && (!m_en || m_occ < lo_eff(m_hi, m_lo))) begin
        m_paused = 0; m_valid = 1; m_time = 0; resumes++;
      end
      m_occ = no; m_hi = nh; m_lo = nl; m_en = ne;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R2", int'(occupancy), m_occ, "occupancy");
      chk(tag, int'(paused), int'(m_paused), "paused");
      chk(tag, int'(req_valid), int'(m_valid), "req_valid");
      if (m_valid) chk(tag, int'(req_time), m_time, "req_time");
    end
    if (cycles > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run(int n, int w, int r, bit ack);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_bytes = INC_W'(w); rd_bytes = INC_W'(r); req_ack = ack; cfg_we = 1'b0;
    end
  endtask

  task automatic cfg(int hi, int lo, bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_hi = CNT_W'(hi); cfg_lo = CNT_W'(lo); cfg_en = en;
    wr_bytes = '0; rd_bytes = '0; req_ack = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    int h0;
    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    chk("R1", int'(occupancy), 0, "occupancy");
    chk("R1", int'(paused), 0, "paused");
    chk("R1", int'(req_valid), 0, "req_valid");
    rst_n = 1'b1;
    // R1: default enable and default high threshold produce a halt
    tag = "R1";
    run(10, 2000, 0, 1'b0);
    chk("R1", halts, 1, "halt count at default threshold");
    run(3, 0, 0, 1'b1);
    run(40, 0, 2000, 1'b1);
    // R9: program small thresholds
    tag = "R9";
    cfg(2000, 1000, 1'b1);
    // R3 and R6: halt held without ack while filling
    tag = "R3";
    run(30, 100, 0, 1'b0);
    tag = "R6";
    chk("R6", int'(req_valid), 1, "held request");
    run(1, 0, 0, 1'b1);
    run(1, 0, 0, 1'b1);
    run(1, 0, 0, 1'b1);
    // R5: still above high, no further request
    tag = "R5";
    h0 = halts;
    run(20, 50, 0, 1'b1);
    run(20, 0, 60, 1'b1);
    chk("R5", halts, h0, "no repeat halt");
    // R4: drain below low
    tag = "R4";
    run(40, 0, 100, 1'b0);
    chk("R4", resumes, 2, "resume count");
    run(2, 0, 0, 1'b1);
    // R6: crossing while a request waits for ack
    tag = "R6";
    run(30, 200, 0, 1'b0);
    run(40, 0, 200, 1'b0);
    run(1, 0, 0, 1'b1);
    run(5, 0, 0, 1'b0);
    run(1, 0, 0, 1'b1);
    run(5, 0, 0, 1'b1);
    // R8: low at or above high
    tag = "R8";
    cfg(1500, 3000, 1'b1);
    run(20, 100, 0, 1'b1);
    run(6, 0, 1, 1'b1);
    run(20, 0, 10, 1'b1);
    run(3, 0, 0, 1'b1);
    run(5, 0, 1, 1'b1);
    cfg(0, 0, 1'b1);
    run(5, 0, 0, 1'b1);
    run(40, 0, 2000, 1'b1);
    // R7: disable while paused gives one resume, then nothing
    tag = "R7";
    cfg(1000, 500, 1'b1);
    run(20, 100, 0, 1'b0);
    cfg(1000, 500, 1'b0);
    run(5, 0, 0, 1'b0);
    run(1, 0, 0, 1'b1);
    h0 = halts;
    run(20, 100, 0, 1'b1);
    chk("R7", halts, h0, "no halt while disabled");
    chk("R7", int'(paused), 0, "not paused while disabled");
    // R2: saturation both ends
    tag = "R2";
    run(25, 2047, 0, 1'b1);
    chk("R2", int'(occupancy), OMAX, "saturated high");
    run(25, 0, 2047, 1'b1);
    chk("R2", int'(occupancy), 0, "saturated low");
    run(3, 5, 9, 1'b1);
    // Mixed pattern with toggling ack and enable
    tag = "R5";
    cfg(3000, 1200, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      wr_bytes = INC_W'(((i * 37) % 11 < 6) ? (i * 13) % 400 : 0);
      rd_bytes = INC_W'(((i / 150) % 2 == 1) ? (i * 7) % 420 : (i * 3) % 90);
      req_ack = ((i * 5) % 7) < 3;
      cfg_we = (i % 700) == 699;
      cfg_en = (i % 1400) != 699;
      cfg_hi = CNT_W'(3000); cfg_lo = CNT_W'(1200);
    end
    run(5, 0, 0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule